// File: doc/BRIEF.md
# Three-Wire Serial Configuration Register Bank

This block is the write-only control port of a transceiver. A host selects the block by pulling an active-low select line low. It then clocks one 24-bit frame in on a serial clock and a data line, and ends the frame by releasing the select line. The leading 20 bits of the frame are register contents and the trailing 4 bits choose the target register. The target register is written only when the select line returns high, and only when exactly 24 bits were clocked in.

The bank holds five 20-bit registers: two divider words, a configuration word, an operating-control word and a test word. All five drive the block's outputs in parallel. A one-cycle write strobe marks the cycle in which a register's new contents appear. Four single-bit control fields come out on their own pins. All other bit positions have no meaning to the block and reach only the parallel register outputs.

All three serial inputs are brought into the system clock domain through two-flop synchronisers followed by an edge detector. The system clock must run at least four times faster than the serial clock.

Top module: `serial_cfg_bank`

## Requirements
- R1: After reset the registers hold their defaults: address 0 (divider A) = 0x00064, address 1 (divider B) = 0x02A00, address 2 (configuration) = 0x00001, address 3 (operating control) = 0x00006, address 4 (test) = 0x00000. All write strobes are low.
- R2: A frame is 24 bits, sent most significant bit first. Frame bits 23:4 are the data and bits 3:0 are the register address (0 to 4). When the frame completes, the data is written to the addressed register.
- R3: A bit is taken only on a rising edge of the serial clock while select is low. Serial clock activity while select is high has no effect. Data changes while the serial clock is high, and falling clock edges, are not sampled.
- R4: A register keeps its old contents for as long as select stays low. It is updated only on the rising edge of select.
- R5: A complete frame whose address is 5 to 15 changes no register and raises no strobe.
- R6: A frame that ends after any bit count other than 24 (for example 23 or 25) changes no register and raises no strobe. The bit count restarts from zero while select is high.
- R7: Each accepted frame raises exactly one strobe: bit n of the strobe vector, where n is the address. The strobe is high for exactly one system clock cycle, the same cycle in which the register first shows its new contents. A register never changes without its strobe.
- R8: The field outputs come from fixed bits. Baseband low-level select is configuration bit 0. Charge-pump boost is operating-control bit 0, buffer enable is bit 1 and buffer divide select is bit 2. The values of all other bits do not affect these outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel_n | input | 1 | Active-low frame select from host |
| host_clk | input | 1 | Serial clock from host |
| host_dat | input | 1 | Serial data from host |
| div_a_o | output | 20 | Divider A register (address 0) |
| div_b_o | output | 20 | Divider B register (address 1) |
| cfg_o | output | 20 | Configuration register (address 2) |
| ctl_o | output | 20 | Operating-control register (address 3) |
| test_o | output | 20 | Test register (address 4) |
| wr_stb_o | output | 5 | One-cycle write strobe per register, bit n for address n |
| bb_low_lvl_o | output | 1 | Baseband low-level select |
| cp_boost_o | output | 1 | Charge-pump current boost |
| lo_buf_en_o | output | 1 | Output buffer enable |
| lo_buf_div_o | output | 1 | Output buffer divide select |

## Verification
A level on a host pin is first seen by the decode logic two system clock edges after it is applied. The edge that detects it fires on the third edge, so a register and its strobe change on the third clock edge after the system clock samples the select line high. The bench's reference model keeps its own four-deep history of the sampled host pins and acts on the entries that are two and three edges old. Its expected registers, strobes and fields therefore change on that same edge. They are compared against the outputs at every falling clock edge, half a cycle after any change. The directed checks wait at least ten cycles after each frame before reading registers, and count strobe pulses over the whole frame, so they do not depend on that exact edge.

// File: rtl/serial_cfg_bank.sv
module serial_cfg_bank #(
  parameter int DATA_W = 20,
  parameter int ADDR_W = 4,
  parameter int SYNC_W = 2,
  parameter logic [DATA_W-1:0] DIVA_RST = 20'h00064,
  parameter logic [DATA_W-1:0] DIVB_RST = 20'h02A00,
  parameter logic [DATA_W-1:0] CFG_RST  = 20'h00001,
  parameter logic [DATA_W-1:0] CTL_RST  = 20'h00006,
  parameter logic [DATA_W-1:0] TEST_RST = 20'h00000,
  parameter int BB_LVL_BIT  = 0,
  parameter int CP_BOOST_BIT = 0,
  parameter int BUF_EN_BIT  = 1,
  parameter int BUF_DIV_BIT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_sel_n,
  input  logic              host_clk,
  input  logic              host_dat,
  output logic [DATA_W-1:0] div_a_o,
  output logic [DATA_W-1:0] div_b_o,
  output logic [DATA_W-1:0] cfg_o,
  output logic [DATA_W-1:0] ctl_o,
  output logic [DATA_W-1:0] test_o,
  output logic [4:0]        wr_stb_o,
  output logic              bb_low_lvl_o,
  output logic              cp_boost_o,
  output logic              lo_buf_en_o,
  output logic              lo_buf_div_o
);

  localparam int NREG    = 5;
  localparam int FRAME_W = DATA_W + ADDR_W;
  localparam int CNT_MAX = FRAME_W + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  function automatic logic [DATA_W-1:0] rst_val(input int idx);
    case (idx)
      0:       return DIVA_RST;
      1:       return DIVB_RST;
      2:       return CFG_RST;
      3:       return CTL_RST;
      default: return TEST_RST;
    endcase
  endfunction

  logic [SYNC_W-1:0]  sclk_sync, dat_sync, sel_sync;
  logic               sclk_prev, sel_prev;
  logic               sclk_s, dat_s, sel_s;
  logic               sclk_rise, sel_rise, frame_ok;
  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   bit_cnt;
  logic [ADDR_W-1:0]  addr;
  logic [DATA_W-1:0]  data;
  logic [DATA_W-1:0]  reg_q [NREG];
  logic [NREG-1:0]    stb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sync <= '0;
      dat_sync  <= '0;
      sel_sync  <= '1;
      sclk_prev <= 1'b0;
      sel_prev  <= 1'b1;
    end else begin
      sclk_sync <= {sclk_sync[SYNC_W-2:0], host_clk};
      dat_sync  <= {dat_sync[SYNC_W-2:0], host_dat};
      sel_sync  <= {sel_sync[SYNC_W-2:0], host_sel_n};
      sclk_prev <= sclk_s;
      sel_prev  <= sel_s;
    end
  end

  assign sclk_s    = sclk_sync[SYNC_W-1];
  assign dat_s     = dat_sync[SYNC_W-1];
  assign sel_s     = sel_sync[SYNC_W-1];
  assign sclk_rise = sclk_s & ~sclk_prev;
  assign sel_rise  = sel_s & ~sel_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      bit_cnt <= '0;
    end else if (sel_s) begin
      bit_cnt <= '0;
    end else if (sclk_rise) begin
      shreg <= {shreg[FRAME_W-2:0], dat_s};
      if (bit_cnt != CNT_W'(CNT_MAX))
        bit_cnt <= bit_cnt + 1'b1;
    end
  end

  assign addr     = shreg[ADDR_W-1:0];
  assign data     = shreg[FRAME_W-1:ADDR_W];
  assign frame_ok = sel_rise && (bit_cnt == CNT_W'(FRAME_W));

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [DATA_W-1:0] RV = rst_val(g);
    logic hit;
    assign hit = frame_ok && (addr == ADDR_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        reg_q[g] <= RV;
        stb_q[g] <= 1'b0;
      end else begin
        stb_q[g] <= hit;
        if (hit) reg_q[g] <= data;
      end
    end

    assert_reg_needs_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(reg_q[g]) |-> stb_q[g]);
  end

  assign div_a_o      = reg_q[0];
  assign div_b_o      = reg_q[1];
  assign cfg_o        = reg_q[2];
  assign ctl_o        = reg_q[3];
  assign test_o       = reg_q[4];
  assign wr_stb_o     = stb_q;
  assign bb_low_lvl_o = reg_q[2][BB_LVL_BIT];
  assign cp_boost_o   = reg_q[3][CP_BOOST_BIT];
  assign lo_buf_en_o  = reg_q[3][BUF_EN_BIT];
  assign lo_buf_div_o = reg_q[3][BUF_DIV_BIT];

  assert_strobe_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stb_q));

  assert_strobe_full_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|stb_q) |-> ($past(bit_cnt) == CNT_W'(FRAME_W)));

  assert_strobe_valid_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|stb_q) |-> ($past(addr) < ADDR_W'(NREG)));

  assert_count_idle_deselected_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sel_s |=> (bit_cnt == '0));

  assert_commit_on_select_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|stb_q) |-> $past(sel_rise));

endmodule

// File: tb/tb_serial_cfg_bank.sv
module tb_serial_cfg_bank;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_sel_n = 1'b1, host_clk = 1'b0, host_dat = 1'b0;
  logic [19:0] div_a_o, div_b_o, cfg_o, ctl_o, test_o;
  logic [4:0] wr_stb_o;
  logic bb_low_lvl_o, cp_boost_o, lo_buf_en_o, lo_buf_div_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  serial_cfg_bank dut (
    .clk(clk), .rst_n(rst_n), .host_sel_n(host_sel_n), .host_clk(host_clk),
    .host_dat(host_dat), .div_a_o(div_a_o), .div_b_o(div_b_o), .cfg_o(cfg_o),
    .ctl_o(ctl_o), .test_o(test_o), .wr_stb_o(wr_stb_o),
    .bb_low_lvl_o(bb_low_lvl_o), .cp_boost_o(cp_boost_o),
    .lo_buf_en_o(lo_buf_en_o), .lo_buf_div_o(lo_buf_div_o)
  );

  localparam logic [19:0] DEF [5] = '{20'h00064, 20'h02A00, 20'h00001, 20'h00006, 20'h00000};

  // reference model: behavioural, keeps a history of sampled host pins
  logic [19:0] m_reg [5];
  logic [4:0]  m_stb;
  logic [2:0]  hist [4];   // {sel, sclk, dat}
  int          m_cnt;
  logic [23:0] m_sh;
  int          stb_seen [5];

  function automatic logic [19:0] pick(input int i);
    case (i)
      0: return div_a_o; 1: return div_b_o; 2: return cfg_o;
      3: return ctl_o; default: return test_o;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 5; i++) m_reg[i] = DEF[i];
      for (int i = 0; i < 4; i++) hist[i] = 3'b100;
      m_stb = '0; m_cnt = 0; m_sh = '0;
    end else begin
      for (int i = 3; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = {host_sel_n, host_clk, host_dat};
      m_stb = '0;
      if (hist[2][2] && !hist[3][2] && m_cnt == 24 && m_sh[3:0] < 5) begin
        m_reg[m_sh[3:0]] = m_sh[23:4];
        m_stb[m_sh[3:0]] = 1'b1;
      end
      if (hist[2][2]) m_cnt = 0;
      else if (hist[2][1] && !hist[3][1]) begin
        m_sh = {m_sh[22:0], hist[2][0]};
        m_cnt = m_cnt + 1;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      for (int i = 0; i < 5; i++) begin
        chk("R2 per-cycle register", {12'h0, pick(i)}, {12'h0, m_reg[i]});
        if (wr_stb_o[i]) stb_seen[i]++;
      end
      chk("R7 per-cycle strobe", {27'h0, wr_stb_o}, {27'h0, m_stb});
      chk("R8 per-cycle fields", {28'h0, bb_low_lvl_o, cp_boost_o, lo_buf_en_o, lo_buf_div_o},
          {28'h0, m_reg[2][0], m_reg[3][0], m_reg[3][1], m_reg[3][2]});
    end
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bits(input logic [31:0] word, input int nbits);
    for (int b = nbits - 1; b >= 0; b--) begin
      host_dat = word[b];
      wait_clk(3);
      host_clk = 1'b1;
      wait_clk(1);
      host_dat = ~word[b];   // change while clock high must be ignored (R3)
      wait_clk(2);
      host_clk = 1'b0;
    end
  endtask

  task automatic send(input logic [31:0] word, input int nbits);
    @(negedge clk);
    host_sel_n = 1'b0;
    wait_clk(3);
    shift_bits(word, nbits);
    wait_clk(3);
    host_sel_n = 1'b1;
    wait_clk(10);
  endtask

  task automatic clr_seen;
    for (int i = 0; i < 5; i++) stb_seen[i] = 0;
  endtask

  task automatic chk_all(input string req, input logic [19:0] e [5]);
    for (int i = 0; i < 5; i++) chk(req, {12'h0, pick(i)}, {12'h0, e[i]});
  endtask

  logic [19:0] exp_r [5];

  initial begin
    clr_seen();
    wait_clk(4);
    // R1: defaults and idle strobes while in reset
    for (int i = 0; i < 5; i++) exp_r[i] = DEF[i];
    chk_all("R1 reset default", exp_r);
    chk("R1 strobes low", {27'h0, wr_stb_o}, 32'h0);
    rst_n = 1'b1;
    wait_clk(4);
    chk_all("R1 default after reset", exp_r);
    chk("R8 default fields", {28'h0, bb_low_lvl_o, cp_boost_o, lo_buf_en_o, lo_buf_div_o}, 32'h3 | 32'h8);

    // R2 and R7: each address written once
    for (int a = 0; a < 5; a++) begin
      logic [19:0] d;
      d = 20'hA5000 ^ (20'h1357 * (a + 1));
      clr_seen();
      send({8'h0, d, 4'(a)}, 24);
      exp_r[a] = d;
      chk_all("R2 frame written", exp_r);
      for (int i = 0; i < 5; i++)
        chk("R7 strobe pulse count", stb_seen[i], (i == a) ? 1 : 0);
    end

    // R4: register held while select low, updated after release
    @(negedge clk);
    host_sel_n = 1'b0;
    wait_clk(3);
    shift_bits({8'h0, 20'h0BEEF, 4'd1}, 24);
    wait_clk(12);
    chk("R4 held while selected", {12'h0, div_b_o}, {12'h0, exp_r[1]});
    host_sel_n = 1'b1;
    wait_clk(10);
    exp_r[1] = 20'h0BEEF;
    chk("R4 updated on select rise", {12'h0, div_b_o}, {12'h0, exp_r[1]});

    // R5: out-of-range addresses
    clr_seen();
    send({8'h0, 20'hFFFFF, 4'd5}, 24);
    send({8'h0, 20'h12345, 4'd15}, 24);
    chk_all("R5 bad address ignored", exp_r);
    chk("R5 no strobe", stb_seen[0] + stb_seen[1] + stb_seen[2] + stb_seen[3] + stb_seen[4], 0);

    // R6: short and long frames
    clr_seen();
    send({9'h0, 19'h7ABCD, 4'd0}, 23);
    send({7'h0, 1'b1, 20'h54321, 4'd2}, 25);
    chk_all("R6 wrong length ignored", exp_r);
    chk("R6 no strobe", stb_seen[0] + stb_seen[1] + stb_seen[2] + stb_seen[3] + stb_seen[4], 0);

    // R3: serial clock toggling while deselected, then a clean frame
    for (int k = 0; k < 5; k++) begin
      host_dat = 1'b1; host_clk = 1'b1; wait_clk(3);
      host_clk = 1'b0; wait_clk(3);
    end
    chk_all("R3 deselected clocks ignored", exp_r);
    send({8'h0, 20'h0C0DE, 4'd4}, 24);
    exp_r[4] = 20'h0C0DE;
    chk("R3 frame after idle clocks", {12'h0, test_o}, {12'h0, exp_r[4]});

    // R8: named fields and don't-care bits
    send({8'h0, 20'hFFFF5, 4'd3}, 24);
    exp_r[3] = 20'hFFFF5;
    chk("R8 fields from ctl", {29'h0, cp_boost_o, lo_buf_en_o, lo_buf_div_o}, 32'h5);
    send({8'h0, 20'h00005, 4'd3}, 24);
    exp_r[3] = 20'h00005;
    chk("R8 dont-care bits ignored", {29'h0, cp_boost_o, lo_buf_en_o, lo_buf_div_o}, 32'h5);
    send({8'h0, 20'hFFFFE, 4'd2}, 24);
    exp_r[2] = 20'hFFFFE;
    chk("R8 baseband level bit", {31'h0, bb_low_lvl_o}, 32'h0);
    chk_all("R2 final register image", exp_r);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule